// File: doc/BRIEF.md
# Shared System-Bus Port Unit

This unit sits between a small processor core and the memory system. It takes two request channels from the core, one for instruction fetches and one for loads and stores, and steers each request by address. Requests to the low code region go to two dedicated single-cycle ports, one for fetches and one for data. Every other address, fetches included, goes to a single shared system bus with a valid/ready handshake.

On the shared bus, one registered slot holds the single transaction in flight. The slot drives the bus. Read data is registered on its way back to the core. When fetch and data both want the slot, the data side is served first. A fetch that loses is owed the next free slot.

Writes to the system bus are posted by default. The core is released in the same cycle the slot accepts the write. A control input turns posting off, and each write then holds the core until the downstream bus has taken it. Each channel holds its request stable until it sees its done strobe.

Top module: `sysport_unit`

## Requirements
- R1: An address whose three top bits are zero is in the code region. A code-region fetch appears on the instruction code port, and a code-region load or store appears on the data code port. Neither ever appears on the system bus. Any address with a nonzero top bit (0x2000_0000 upward) uses the system bus.
- R2: A code-region access completes (done high, read data valid) in the cycle after the cycle in which the request was first presented, so two sampled cycles from request to done.
- R3: A system-bus read presented to an idle unit with no wait states completes two cycles after it was presented: slot load, bus handshake, then registered return. Done comes one cycle after the bus handshake, with the data the bus returned at the handshake.
- R4: When a fetch and a data access are both waiting for a free slot, the data access enters the bus first.
- R5: A fetch that lost the slot to a data access wins the next free slot, even if another data access is waiting by then.
- R6: While post_dis is low, a system-bus write completes in the same cycle it is accepted into the slot, whatever the downstream wait states.
- R7: A system-bus access cannot enter the slot while a posted write still occupies it. With three wait states, a write issued right after a posted write completes five sampled cycles after it is presented.
- R8: While post_dis is high, a system-bus write completes only in the cycle after its downstream handshake.
- R9: A read that follows a posted write to the same address is issued on the bus after the write handshake, and it returns the written data.
- R10: While sys_valid is high and sys_ready low, sys_valid, sys_we, sys_addr and sys_wdata hold their values into the next cycle.
- R11: In reset and on the first cycle after it, with no requests present, sys_valid, both done strobes and both code-port requests are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_dis | input | 1 | High: system-bus writes are not posted |
| fch_req | input | 1 | Fetch request, held until fch_done |
| fch_addr | input | 32 | Fetch address |
| fch_done | output | 1 | Fetch complete, fch_rdata valid |
| fch_rdata | output | 32 | Fetch data |
| dat_req | input | 1 | Load/store request, held until dat_done |
| dat_we | input | 1 | High for a store |
| dat_addr | input | 32 | Load/store address |
| dat_wdata | input | 32 | Store data |
| dat_done | output | 1 | Load/store complete, dat_rdata valid for loads |
| dat_rdata | output | 32 | Load data |
| icode_req | output | 1 | Instruction code-port read strobe |
| icode_addr | output | 32 | Instruction code-port address |
| icode_rdata | input | 32 | Instruction code-port data, one cycle after the strobe |
| dcode_req | output | 1 | Data code-port strobe |
| dcode_we | output | 1 | Data code-port write enable |
| dcode_addr | output | 32 | Data code-port address |
| dcode_wdata | output | 32 | Data code-port write data |
| dcode_rdata | input | 32 | Data code-port read data, one cycle after the strobe |
| sys_valid | output | 1 | System-bus request valid |
| sys_we | output | 1 | System-bus write |
| sys_addr | output | 32 | System-bus address |
| sys_wdata | output | 32 | System-bus write data |
| sys_ready | input | 1 | System-bus accept; read data valid in that cycle |
| sys_rdata | input | 32 | System-bus read data |

## Verification
The properties assume a core that keeps each request and its address, direction and data unchanged until the matching done strobe. They also assume post_dis changes only while both channels are idle, and that the code ports return data exactly one cycle after their strobe. The bench drives its channels through tasks that hold the request until done and then drop or replace it right after the clock edge. It changes post_dis and the wait-state count only between operations, and its code-port models are single-cycle registered memories. The downstream model raises ready only in response to sys_valid, after a configurable number of wait cycles.

// File: rtl/spu_pkg.sv
package spu_pkg;

    parameter int SPU_AW = 32;
    parameter int SPU_DW = 32;

    typedef enum logic {
        OWN_FCH = 1'b0,
        OWN_DAT = 1'b1
    } owner_e;

    // one transaction held in the system-port slot
    typedef struct packed {
        logic              we;
        logic [SPU_AW-1:0] addr;
        logic [SPU_DW-1:0] wdata;
        owner_e            owner;
        logic              posted;
    } sys_req_t;

    // registered return toward the core
    typedef struct packed {
        logic              valid;
        owner_e            owner;
        logic [SPU_DW-1:0] data;
    } sys_rsp_t;

    // true when the nb top address bits are all zero
    function automatic logic in_code(input logic [SPU_AW-1:0] a, input int nb);
        logic r;
        r = 1'b1;
        for (int i = 0; i < SPU_AW; i++) begin
            if ((i >= SPU_AW - nb) && a[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/spu_code_path.sv
module spu_code_path
    import spu_pkg::*;
#(
    parameter int CODE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              pend,
    input  logic [SPU_AW-1:0] addr,
    output logic              issue,
    output logic              done
);

    logic wait_q;

    assign issue = req && !pend && in_code(addr, CODE_BITS);
    assign done  = wait_q;

    always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b0;
        else     wait_q <= issue;
    end

endmodule

// File: rtl/spu_arbiter.sv
module spu_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic slot_free,
    input  logic f_cand,
    input  logic d_cand,
    output logic f_win,
    output logic d_win
);

    logic owed_q;

    assign f_win = slot_free && f_cand && (owed_q || !d_cand);
    assign d_win = slot_free && d_cand && !f_win;

    always_ff @(posedge clk) begin
        if (rst)                  owed_q <= 1'b0;
        else if (f_win)           owed_q <= 1'b0;
        else if (d_win && f_cand) owed_q <= 1'b1;
    end

endmodule

// File: rtl/spu_sys_slot.sv
module spu_sys_slot
    import spu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  sys_req_t          load_req,
    input  logic              s_ready,
    input  logic [SPU_DW-1:0] s_rdata,
    output logic              slot_free,
    output logic              s_valid,
    output logic              s_we,
    output logic [SPU_AW-1:0] s_addr,
    output logic [SPU_DW-1:0] s_wdata,
    output sys_rsp_t          rsp
);

    sys_req_t slot_q;
    logic     slot_v;
    logic     hs;
    sys_rsp_t rsp_q;

    assign hs        = slot_v && s_ready;
    assign slot_free = !slot_v;
    assign s_valid   = slot_v;
    assign s_we      = slot_q.we;
    assign s_addr    = slot_q.addr;
    assign s_wdata   = slot_q.wdata;
    assign rsp       = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= 1'b0;
            slot_q <= '0;
        end else if (load) begin
            slot_v <= 1'b1;
            slot_q <= load_req;
        end else if (hs) begin
            slot_v <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= hs && !(slot_q.we && slot_q.posted);
            rsp_q.owner <= slot_q.owner;
            rsp_q.data  <= s_rdata;
        end
    end

endmodule

// File: rtl/sysport_unit.sv
module sysport_unit
    import spu_pkg::*;
#(
    parameter int CODE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_dis,
    input  logic              fch_req,
    input  logic [SPU_AW-1:0] fch_addr,
    output logic              fch_done,
    output logic [SPU_DW-1:0] fch_rdata,
    input  logic              dat_req,
    input  logic              dat_we,
    input  logic [SPU_AW-1:0] dat_addr,
    input  logic [SPU_DW-1:0] dat_wdata,
    output logic              dat_done,
    output logic [SPU_DW-1:0] dat_rdata,
    output logic              icode_req,
    output logic [SPU_AW-1:0] icode_addr,
    input  logic [SPU_DW-1:0] icode_rdata,
    output logic              dcode_req,
    output logic              dcode_we,
    output logic [SPU_AW-1:0] dcode_addr,
    output logic [SPU_DW-1:0] dcode_wdata,
    input  logic [SPU_DW-1:0] dcode_rdata,
    output logic              sys_valid,
    output logic              sys_we,
    output logic [SPU_AW-1:0] sys_addr,
    output logic [SPU_DW-1:0] sys_wdata,
    input  logic              sys_ready,
    input  logic [SPU_DW-1:0] sys_rdata
);

    logic     f_pend, d_pend;
    logic     f_cissue, d_cissue, f_cwait, d_cwait;
    logic     f_cand, d_cand, f_win, d_win;
    logic     slot_free, posted_now;
    sys_req_t ld;
    sys_rsp_t rsp;

    // code-region paths
    spu_code_path #(.CODE_BITS(CODE_BITS)) i_icode (
        .clk(clk), .rst(rst), .req(fch_req), .pend(f_pend),
        .addr(fch_addr), .issue(f_cissue), .done(f_cwait)
    );
    spu_code_path #(.CODE_BITS(CODE_BITS)) i_dcode (
        .clk(clk), .rst(rst), .req(dat_req), .pend(d_pend),
        .addr(dat_addr), .issue(d_cissue), .done(d_cwait)
    );

    assign icode_req   = f_cissue;
    assign icode_addr  = fch_addr;
    assign dcode_req   = d_cissue;
    assign dcode_we    = dat_we;
    assign dcode_addr  = dat_addr;
    assign dcode_wdata = dat_wdata;

    // system-port candidates and arbitration
    assign f_cand = fch_req && !f_pend && !in_code(fch_addr, CODE_BITS);
    assign d_cand = dat_req && !d_pend && !in_code(dat_addr, CODE_BITS);

    spu_arbiter i_arb (
        .clk(clk), .rst(rst), .slot_free(slot_free),
        .f_cand(f_cand), .d_cand(d_cand), .f_win(f_win), .d_win(d_win)
    );

    assign posted_now = d_win && dat_we && !post_dis;

    always_comb begin
        ld = '0;
        if (d_win) begin
            ld.we     = dat_we;
            ld.addr   = dat_addr;
            ld.wdata  = dat_wdata;
            ld.owner  = OWN_DAT;
            ld.posted = posted_now;
        end else begin
            ld.we     = 1'b0;
            ld.addr   = fch_addr;
            ld.owner  = OWN_FCH;
            ld.posted = 1'b0;
        end
    end

    spu_sys_slot i_slot (
        .clk(clk), .rst(rst), .load(f_win || d_win), .load_req(ld),
        .s_ready(sys_ready), .s_rdata(sys_rdata), .slot_free(slot_free),
        .s_valid(sys_valid), .s_we(sys_we), .s_addr(sys_addr),
        .s_wdata(sys_wdata), .rsp(rsp)
    );

    // completion toward the core
    assign fch_done  = f_cwait || (rsp.valid && rsp.owner == OWN_FCH);
    assign fch_rdata = f_cwait ? icode_rdata : rsp.data;
    assign dat_done  = d_cwait || (rsp.valid && rsp.owner == OWN_DAT) || posted_now;
    assign dat_rdata = d_cwait ? dcode_rdata : rsp.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_pend <= 1'b0;
            d_pend <= 1'b0;
        end else begin
            f_pend <= f_pend ? !fch_done : (f_cissue || f_win);
            d_pend <= d_pend ? !dat_done : (d_cissue || (d_win && !posted_now));
        end
    end

endmodule

// File: rtl/sysport_chk.sv
module sysport_chk
    import spu_pkg::*;
#(
    parameter int CODE_BITS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              post_dis,
    input logic              fch_done,
    input logic              dat_req,
    input logic              dat_we,
    input logic [SPU_AW-1:0] dat_addr,
    input logic              dat_done,
    input logic              icode_req,
    input logic              dcode_req,
    input logic              sys_valid,
    input logic              sys_we,
    input logic [SPU_AW-1:0] sys_addr,
    input logic [SPU_DW-1:0] sys_wdata,
    input logic              sys_ready
);

    p_route_r1: assert property (@(posedge clk) disable iff (rst)
        sys_valid |-> !in_code(sys_addr, CODE_BITS));

    p_icode_lat_r2: assert property (@(posedge clk) disable iff (rst)
        icode_req |=> fch_done);

    p_dcode_lat_r2: assert property (@(posedge clk) disable iff (rst)
        dcode_req |=> dat_done);

    p_sys_return_r3: assert property (@(posedge clk) disable iff (rst)
        (sys_valid && sys_ready && !sys_we) |=> (fch_done || dat_done));

    p_posted_r6: assert property (@(posedge clk) disable iff (rst)
        (dat_req && dat_we && !post_dis && !in_code(dat_addr, CODE_BITS) && dat_done)
        |=> sys_valid);

    p_blocking_r8: assert property (@(posedge clk) disable iff (rst)
        (post_dis && dat_req && dat_we && !in_code(dat_addr, CODE_BITS) && dat_done)
        |-> $past(sys_valid && sys_ready && sys_we));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (sys_valid && !sys_ready) |=>
        (sys_valid && $stable(sys_we) && $stable(sys_addr) && $stable(sys_wdata)));

endmodule

bind sysport_unit sysport_chk #(.CODE_BITS(CODE_BITS)) i_chk (
    .clk(clk), .rst(rst), .post_dis(post_dis), .fch_done(fch_done),
    .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_done(dat_done), .icode_req(icode_req), .dcode_req(dcode_req),
    .sys_valid(sys_valid), .sys_we(sys_we), .sys_addr(sys_addr),
    .sys_wdata(sys_wdata), .sys_ready(sys_ready)
);

// File: tb/test_sysport_unit.sv
module test_sysport_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_dis = 1'b0;
    logic        fch_req = 1'b0;
    logic [31:0] fch_addr = '0;
    logic        fch_done;
    logic [31:0] fch_rdata;
    logic        dat_req = 1'b0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_addr = '0;
    logic [31:0] dat_wdata = '0;
    logic        dat_done;
    logic [31:0] dat_rdata;
    logic        icode_req;
    logic [31:0] icode_addr;
    logic [31:0] icode_rdata;
    logic        dcode_req;
    logic        dcode_we;
    logic [31:0] dcode_addr;
    logic [31:0] dcode_wdata;
    logic [31:0] dcode_rdata;
    logic        sys_valid;
    logic        sys_we;
    logic [31:0] sys_addr;
    logic [31:0] sys_wdata;
    logic        sys_ready;
    logic [31:0] sys_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sysport_unit i_sysport_unit (
        .clk(clk), .rst(rst), .post_dis(post_dis),
        .fch_req(fch_req), .fch_addr(fch_addr), .fch_done(fch_done), .fch_rdata(fch_rdata),
        .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
        .dat_done(dat_done), .dat_rdata(dat_rdata),
        .icode_req(icode_req), .icode_addr(icode_addr), .icode_rdata(icode_rdata),
        .dcode_req(dcode_req), .dcode_we(dcode_we), .dcode_addr(dcode_addr),
        .dcode_wdata(dcode_wdata), .dcode_rdata(dcode_rdata),
        .sys_valid(sys_valid), .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
        .sys_ready(sys_ready), .sys_rdata(sys_rdata)
    );

    // ---------------- downstream and code-port models ----------------
    int          ws = 0;
    int          wcnt = 0;
    logic [31:0] smem [16];
    logic [31:0] cmem [4];
    logic [31:0] log_addr [64];
    logic        log_we [64];
    int          log_n = 0;

    assign sys_ready = sys_valid && (wcnt >= ws);
    assign sys_rdata = smem[sys_addr[5:2]];

    always @(posedge clk) begin
        if (rst) begin
            wcnt <= 0;
            for (int i = 0; i < 16; i++) smem[i] <= 32'h5000_0000 + i;
        end else begin
            if (sys_valid && !sys_ready) wcnt <= wcnt + 1;
            else                         wcnt <= 0;
            if (sys_valid && sys_ready) begin
                if (sys_we) smem[sys_addr[5:2]] <= sys_wdata;
                if (log_n < 64) begin
                    log_addr[log_n] <= sys_addr;
                    log_we[log_n]   <= sys_we;
                    log_n           <= log_n + 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (icode_req) icode_rdata <= icode_addr ^ 32'hA5A5_0000;
        if (dcode_req) begin
            if (dcode_we) cmem[dcode_addr[3:2]] <= dcode_wdata;
            else          dcode_rdata <= cmem[dcode_addr[3:2]];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // inputs change 1 ns after a rising edge; outputs sampled at falling edges
    task automatic do_op(input bit fch, input bit we, input logic [31:0] addr,
                         input logic [31:0] wdata, output int lat, output logic [31:0] rd);
        if (fch) begin fch_req = 1'b1; fch_addr = addr; end
        else begin dat_req = 1'b1; dat_we = we; dat_addr = addr; dat_wdata = wdata; end
        lat = 0;
        rd  = '0;
        while (lat < 99) begin
            @(negedge clk);
            lat++;
            if (fch && fch_done)  begin rd = fch_rdata; break; end
            if (!fch && dat_done) begin rd = dat_rdata; break; end
        end
        @(posedge clk);
        #1;
        if (fch) fch_req = 1'b0;
        else     dat_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        fch;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  lat;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 32'h4000_0008, 32'h1111_2222, 8'd1, 32'h0},          // R6 posted
        '{1'b0, 1'b0, 32'h4000_0008, 32'h0,         8'd3, 32'h1111_2222},  // R3 sys load
        '{1'b1, 1'b0, 32'h2000_0010, 32'h0,         8'd3, 32'h5000_0004},  // R3 sys fetch
        '{1'b1, 1'b0, 32'h0000_0100, 32'h0,         8'd2, 32'hA5A5_0100},  // R2 code fetch
        '{1'b0, 1'b1, 32'h1000_0004, 32'hCAFE_F00D, 8'd2, 32'h0},          // R1 code store
        '{1'b0, 1'b0, 32'h1000_0004, 32'h0,         8'd2, 32'hCAFE_F00D},  // R1 code load
        '{1'b1, 1'b0, 32'h1FFF_FFFC, 32'h0,         8'd2, 32'hBA5A_FFFC},  // R1 top of code
        '{1'b0, 1'b0, 32'h2000_0000, 32'h0,         8'd3, 32'h5000_0000}   // R1 first sys addr
    };

    // ---------------- main sequence ----------------
    initial begin : main
        int          lat, lat2, lf, ld;
        logic [31:0] rd, rf;
        int          base;
        int          bad;

        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!sys_valid && !fch_done && !dat_done && !icode_req && !dcode_req,
            "R11 outputs in reset",
            {27'd0, sys_valid, fch_done, dat_done, icode_req, dcode_req}, 32'h0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!sys_valid && !fch_done && !dat_done && !icode_req && !dcode_req,
            "R11 outputs after reset",
            {27'd0, sys_valid, fch_done, dat_done, icode_req, dcode_req}, 32'h0);
        @(posedge clk);
        #1;

        // table walk, unloaded bus
        for (int v = 0; v < NV; v++) begin
            bit sys;
            sys  = (VECS[v].addr[31:29] != 3'b000);
            base = log_n;
            do_op(VECS[v].fch, VECS[v].we, VECS[v].addr, VECS[v].wdata, lat, rd);
            chk(lat == int'(VECS[v].lat), $sformatf("R2/R3/R6 latency vec%0d", v),
                lat, VECS[v].lat);
            if (!VECS[v].we)
                chk(rd == VECS[v].rd, $sformatf("R3 read data vec%0d", v), rd, VECS[v].rd);
            idle(3);
            chk((log_n - base) == (sys ? 1 : 0), $sformatf("R1 routing vec%0d", v),
                log_n - base, sys ? 1 : 0);
        end

        // R4 data before fetch
        base = log_n;
        fork
            do_op(1'b1, 1'b0, 32'h3000_0000, 32'h0, lf, rf);
            do_op(1'b0, 1'b0, 32'h4000_0004, 32'h0, ld, rd);
        join
        idle(3);
        chk(log_addr[base] == 32'h4000_0004, "R4 data first on bus", log_addr[base], 32'h4000_0004);
        chk(ld == 3 && lf == 5, "R4 latencies", {ld[15:0], lf[15:0]}, {16'd3, 16'd5});

        // R5 fetch owed after losing to a stream of posted writes
        base = log_n;
        fork
            do_op(1'b1, 1'b0, 32'h3000_0008, 32'h0, lf, rf);
            begin
                do_op(1'b0, 1'b1, 32'h4000_0010, 32'hAAAA_0001, ld, rd);
                do_op(1'b0, 1'b1, 32'h4000_0014, 32'hAAAA_0002, ld, rd);
                do_op(1'b0, 1'b1, 32'h4000_0018, 32'hAAAA_0003, ld, rd);
            end
        join
        idle(4);
        chk(log_addr[base+1] == 32'h3000_0008, "R5 fetch takes next free slot",
            log_addr[base+1], 32'h3000_0008);
        chk(lf == 5, "R5 fetch latency", lf, 5);

        // R6/R7 posted write then a second write with wait states
        ws = 3;
        do_op(1'b0, 1'b1, 32'h4000_0020, 32'hBBBB_0001, lat, rd);
        do_op(1'b0, 1'b1, 32'h4000_0024, 32'hBBBB_0002, lat2, rd);
        chk(lat == 1, "R6 posted despite wait states", lat, 1);
        chk(lat2 == 5, "R7 second write stalls", lat2, 5);
        idle(8);

        // R9 read behind posted write to the same address
        base = log_n;
        do_op(1'b0, 1'b1, 32'h4000_0028, 32'hDEAD_BEEF, lat, rd);
        do_op(1'b0, 1'b0, 32'h4000_0028, 32'h0, lat2, rd);
        chk(rd == 32'hDEAD_BEEF, "R9 read sees buffered write", rd, 32'hDEAD_BEEF);
        chk(lat2 == 10, "R9 read waits for drain", lat2, 10);
        chk(log_we[base] == 1'b1 && log_we[base+1] == 1'b0, "R9 bus order",
            {30'd0, log_we[base], log_we[base+1]}, 32'h2);
        idle(3);

        // R8 posting disabled
        post_dis = 1'b1;
        ws = 2;
        do_op(1'b0, 1'b1, 32'h4000_002C, 32'h0000_1234, lat, rd);
        chk(lat == 5, "R8 blocking write with waits", lat, 5);
        ws = 0;
        idle(2);
        do_op(1'b0, 1'b1, 32'h4000_0034, 32'h0000_5678, lat, rd);
        chk(lat == 3, "R8 blocking write no waits", lat, 3);
        idle(2);
        post_dis = 1'b0;

        // R10 request held while the bus inserts wait states
        ws  = 4;
        bad = 0;
        fork
            do_op(1'b0, 1'b0, 32'h4000_0030, 32'h0, lat, rd);
            repeat (8) begin
                @(negedge clk);
                if (sys_valid && !sys_ready && (sys_addr != 32'h4000_0030 || sys_we)) bad++;
            end
        join
        chk(bad == 0, "R10 request stable under wait", bad, 0);
        chk(lat == 7, "R10 latency with four waits", lat, 7);
        chk(rd == 32'h5000_000C, "R10 read data", rd, 32'h5000_000C);
        ws = 0;
        idle(3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule